// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Receiver

This block is the receive half of a clock-synchronous serial link in which it is the clock master. It drives a serial clock, samples one data input on each rising edge of that clock, assembles 8-bit words with the most significant bit first, and presents each word to a host through a four-entry register window. The serial clock is derived from the system clock by a programmable even ratio. When the link is idle the clock rests high.

The host starts a burst by enabling the receiver and then reading the data register once. The value that read returns is not used. After that first word, words follow each other with no further host action. A stop control ends the burst after the word in progress. Clearing the enable does the same. Each read of the data register consumes the held word and clears the full flag. If a word completes while the previous one is still unread, the new word is discarded and the overrun flag is raised. The burst then stops, and it cannot be restarted until the host clears that flag. To collect the final word of a burst without starting another, the host first clears both control bits and only then reads the data register.

Top module: `rxs_master_rx`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, the divider register reads the parameter DIV_RST (2), and `sclk_o` is high.
- R2: Register map on `reg_addr`: 0 = received word (read), 1 = status, 2 = control, 3 = divider. Status bit 0 is full, bit 1 is overrun and bit 2 is busy. Control bit 0 is enable and bit 1 is stop-after-word. Control and divider read back the values written to them.
- R3: A read of address 0 while enable is 1, overrun is 0 and the receiver is idle starts reception, and busy reads 1 afterwards. The same read with enable at 0 starts nothing.
- R4: While busy, `sclk_o` is low for H system clocks and then high for H system clocks, where H is the divider value and a value of 0 counts as 1. While idle, `sclk_o` is high.
- R5: `sdi_i` is sampled at each rising transition of `sclk_o`. Eight samples form one word, and the first sample becomes bit 7.
- R6: A completed word is stored and sets full. A read of address 0 returns the stored word and clears full.
- R7: With enable 1 and stop 0, a new word begins right after the previous one, with no host action.
- R8: A word that completes while full is 1, with no data read in the same cycle, sets overrun. That word is discarded, the stored word is kept, and the receiver goes idle.
- R9: While overrun is 1, a read of address 0 does not start reception. Writing status with bit 1 at 0 clears overrun, and writing it with bit 1 at 1 leaves overrun unchanged.
- R10: With stop at 1, the receiver finishes the current word, then goes idle with `sclk_o` high.
- R11: Clearing enable during a word lets that word finish, and the receiver then goes idle.
- R12: Once enable is 0, reading the final word does not restart reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| sclk_o | output | 1 | Serial clock, high when idle |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions assume that the divider register is not rewritten while a burst is running. They also assume that the serial data input is stable around each rising transition of `sclk_o`. The bench's slave model changes `sdi_i` only on falling transitions of `sclk_o`. The bench writes the divider only while status shows the receiver idle. The bench sends every started word to completion, so its bit position never falls out of step with the receiver.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_STAT = 2'd1,
    RA_CTRL = 2'd2,
    RA_DIV  = 2'd3
  } reg_addr_e;

  localparam int STAT_FULL = 0;
  localparam int STAT_OVR  = 1;
  localparam int STAT_BUSY = 2;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_HALT = 1;
endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rxs_clkgen.sv
module rxs_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             sclk,
  output logic             rise
);
  logic [DIV_W-1:0] cnt_q, cnt_d, half_m1;
  logic             sclk_q, sclk_d;
  logic             wrap;

  // divider value 0 behaves as 1
  assign half_m1 = (div_val == '0) ? '0 : div_val - 1'b1;
  assign wrap    = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = half_m1;
      sclk_d = 1'b1;
    end else if (wrap) begin
      cnt_d  = half_m1;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  assign rise = run & wrap & ~sclk_q;
endmodule

// File: rtl/rxs_shift.sv
module rxs_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              smp,
  input  logic              sdi,
  output logic              done,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-2:0] sh_q, sh_d;
  logic              sh_en;
  logic              at_last;

  assign at_last = (cnt_q == LAST);
  assign sh_en   = active & smp;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (!active) begin
      cnt_d = '0;
    end else if (smp) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
      sh_d  = {sh_q[DATA_W-3:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign done = sh_en & at_last;
  assign word = {sh_q, sdi};
endmodule

// File: rtl/rxs_ctl.sv
module rxs_ctl
  import rxs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int BUS_W   = 8,
  parameter int DIV_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  output logic              busy,
  output logic [DIV_W-1:0]  div_val,
  output logic              full,
  output logic              ovr,
  output logic              halt,
  output logic [DATA_W-1:0] rx_data
);
  reg_addr_e         sel;
  logic              rd_dat, wr_stat, wr_ctrl, wr_div;
  logic              start, collide, ld_rx;
  logic [DATA_W-1:0] rx_q;
  logic              full_q, full_d, ovr_q, ovr_d, busy_q, busy_d;
  logic              en_q, en_d, halt_q, halt_d;
  logic [DIV_W-1:0]  div_q, div_d;

  assign sel     = reg_addr_e'(addr);
  assign rd_dat  = rd & (sel == RA_DATA);
  assign wr_stat = wr & (sel == RA_STAT);
  assign wr_ctrl = wr & (sel == RA_CTRL);
  assign wr_div  = wr & (sel == RA_DIV);

  assign start   = rd_dat & en_q & ~ovr_q & ~busy_q;
  assign collide = done & full_q & ~rd_dat;
  assign ld_rx   = done & ~collide;

  always_comb begin
    en_d   = en_q;
    halt_d = halt_q;
    div_d  = div_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    busy_d = busy_q;
    if (wr_ctrl) begin
      en_d   = wdata[CTRL_EN];
      halt_d = wdata[CTRL_HALT];
    end
    if (wr_div) div_d = wdata[DIV_W-1:0];
    if (rd_dat) full_d = 1'b0;
    if (wr_stat && !wdata[STAT_OVR]) ovr_d = 1'b0;
    if (collide) ovr_d = 1'b1;
    if (ld_rx) full_d = 1'b1;
    if (start) busy_d = 1'b1;
    else if (done && (halt_q || !en_q || collide)) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      halt_q <= 1'b0;
      div_q  <= DIV_W'(DIV_RST);
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      halt_q <= halt_d;
      div_q  <= div_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (ld_rx) rx_q <= word;
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      RA_DATA: rdata = BUS_W'(rx_q);
      RA_STAT: begin
        rdata[STAT_FULL] = full_q;
        rdata[STAT_OVR]  = ovr_q;
        rdata[STAT_BUSY] = busy_q;
      end
      RA_CTRL: begin
        rdata[CTRL_EN]   = en_q;
        rdata[CTRL_HALT] = halt_q;
      end
      RA_DIV:  rdata = BUS_W'(div_q);
      default: rdata = '0;
    endcase
  end

  assign busy    = busy_q;
  assign div_val = div_q;
  assign full    = full_q;
  assign ovr     = ovr_q;
  assign halt    = halt_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/rxs_master_rx.sv
module rxs_master_rx #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int BUS_W   = 8,
  parameter int DIV_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             sclk_o,
  input  logic             sdi_i
);
  logic              rst_sync_n;
  logic              busy_w, rise_w, done_w, full_w, ovr_w, halt_w;
  logic [DIV_W-1:0]  div_w;
  logic [DATA_W-1:0] word_w, rx_w;

  rxs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxs_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (busy_w),
    .div_val (div_w),
    .sclk    (sclk_o),
    .rise    (rise_w)
  );

  rxs_shift #(.DATA_W(DATA_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .active (busy_w),
    .smp    (rise_w),
    .sdi    (sdi_i),
    .done   (done_w),
    .word   (word_w)
  );

  rxs_ctl #(
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .BUS_W   (BUS_W),
    .DIV_RST (DIV_RST)
  ) u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .done    (done_w),
    .word    (word_w),
    .busy    (busy_w),
    .div_val (div_w),
    .full    (full_w),
    .ovr     (ovr_w),
    .halt    (halt_w),
    .rx_data (rx_w)
  );
endmodule

// File: rtl/rxs_master_rx_chk.sv
module rxs_master_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              busy,
  input logic              full,
  input logic              ovr,
  input logic              done,
  input logic              halt,
  input logic [DATA_W-1:0] rx_data
);
  a_r4_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  a_r6_word_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> full);

  a_r8_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> (rx_data == $past(rx_data)));

  a_r8_overrun_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> !busy);

  a_r9_no_start_in_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !busy) |=> !busy);

  a_r10_stop_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done && halt) |=> !busy);
endmodule

bind rxs_master_rx rxs_master_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sclk    (sclk_o),
  .busy    (busy_w),
  .full    (full_w),
  .ovr     (ovr_w),
  .done    (done_w),
  .halt    (halt_w),
  .rx_data (rx_w)
);

// File: tb/sim_rxs_master_rx.sv
`timescale 1ns/1ps
module sim_rxs_master_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sclk_o;
  logic       sdi_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  bit         mon_arm = 1'b0;
  string      mon_tag = "";

  always #4 clk = ~clk;

  rxs_master_rx u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sclk_o    (sclk_o),
    .sdi_i     (sdi_i)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // serial slave: next bit presented on each falling clock edge
  int         bit_i = 0;
  logic [7:0] cur = 8'h00;
  always @(negedge sclk_o) begin
    if (bit_i == 0) cur = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
    sdi_i = cur[7 - bit_i];
    bit_i = (bit_i + 1) % 8;
  end

  // scoreboard monitor: compares each armed data-register read
  always @(posedge clk) begin
    if (mon_arm && reg_rd && reg_addr == 2'd0) begin
      if (exp_q.size() == 0) check({mon_tag, " (no expected word)"}, reg_rdata, 256);
      else check(mon_tag, reg_rdata, exp_q.pop_front());
    end
  end

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send(logic [7:0] b, bit expect_it);
    tx_q.push_back(b);
    if (expect_it) exp_q.push_back(b);
  endtask

  task automatic read_word(string tag);
    logic [7:0] v;
    mon_tag = tag;
    mon_arm = 1'b1;
    reg_read(2'd0, v);
    mon_arm = 1'b0;
  endtask

  task automatic dummy_read();
    logic [7:0] v;
    reg_read(2'd0, v);
  endtask

  task automatic wait_stat(int bpos, logic val, string tag);
    logic [7:0] v;
    bit ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      reg_read(2'd1, v);
      if (v[bpos] == val) begin ok = 1'b1; break; end
    end
    if (!ok) check({tag, " wait timeout"}, 0, 1);
  endtask

  task automatic expect_reg(logic [1:0] a, logic [7:0] e, string tag);
    logic [7:0] v;
    reg_read(a, v);
    check(tag, v, e);
  endtask

  task automatic measure(int h, string tag);
    int n;
    @(negedge sclk_o);
    #1 n = 0;
    while (sclk_o == 1'b0 && n < 300) begin @(posedge clk); #1 n++; end
    check({tag, " low width"}, n, h);
    n = 0;
    while (sclk_o == 1'b1 && n < 300) begin @(posedge clk); #1 n++; end
    check({tag, " high width"}, n, h);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 sclk idle", sclk_o, 1);
    expect_reg(2'd1, 8'h00, "R1 status");
    expect_reg(2'd2, 8'h00, "R1 control");
    expect_reg(2'd3, 8'h02, "R1 divider");

    // R3 no start while disabled
    dummy_read();
    repeat (10) @(negedge clk);
    expect_reg(2'd1, 8'h00, "R3 disabled read idle");
    check("R3 disabled sclk", sclk_o, 1);

    // R2 register readback
    reg_write(2'd3, 8'h03);
    expect_reg(2'd3, 8'h03, "R2 divider readback");
    reg_write(2'd2, 8'h01);
    expect_reg(2'd2, 8'h01, "R2 control readback");

    // R4 R5 R6 R7 continuous burst, then R10 stop and R12 final read
    send(8'hA5, 1'b1);
    send(8'h3C, 1'b1);
    dummy_read();
    measure(3, "R4 div3");
    expect_reg(2'd1, 8'h04, "R3 busy after start");
    wait_stat(0, 1'b1, "R6 full");
    read_word("R5 first word msb-first");
    expect_reg(2'd1, 8'h04, "R7 continues busy, full cleared R6");
    reg_write(2'd2, 8'h03);
    wait_stat(2, 1'b0, "R10 idle");
    check("R10 sclk high", sclk_o, 1);
    expect_reg(2'd1, 8'h01, "R10 word held");
    reg_write(2'd2, 8'h00);
    read_word("R7 second word");
    repeat (20) @(negedge clk);
    expect_reg(2'd1, 8'h00, "R12 no restart");

    // R8 overrun with divider 0 (R4 as 1)
    reg_write(2'd3, 8'h00);
    reg_write(2'd2, 8'h01);
    send(8'h11, 1'b1);
    send(8'h22, 1'b0);
    dummy_read();
    measure(1, "R4 div0");
    wait_stat(2, 1'b0, "R8 idle");
    expect_reg(2'd1, 8'h03, "R8 overrun+full");
    read_word("R8 older word kept");
    repeat (20) @(negedge clk);
    expect_reg(2'd1, 8'h02, "R9 read no restart");
    reg_write(2'd1, 8'h02);
    expect_reg(2'd1, 8'h02, "R9 write one keeps overrun");
    reg_write(2'd1, 8'h00);
    expect_reg(2'd1, 8'h00, "R9 cleared");
    send(8'h44, 1'b1);
    reg_write(2'd2, 8'h03);
    dummy_read();
    expect_reg(2'd1, 8'h04, "R9 restart after clear");
    wait_stat(2, 1'b0, "R9 idle");
    reg_write(2'd2, 8'h00);
    read_word("R9 word after restart");

    // R11 enable cleared mid-word
    reg_write(2'd3, 8'h02);
    reg_write(2'd2, 8'h01);
    send(8'h5A, 1'b1);
    dummy_read();
    repeat (6) @(negedge clk);
    reg_write(2'd2, 8'h00);
    wait_stat(2, 1'b0, "R11 idle");
    expect_reg(2'd1, 8'h01, "R11 word finished");
    read_word("R11 word value");
    check("R11 no extra word consumed", tx_q.size(), 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule